// File: doc/BRIEF.md
# Core Supply Wakeup Sequencer

This block runs the power-down and power-up order for a core supply domain that is switched off during sleep. When software asks for sleep, it first drops the domain's ready flag, then turns off the core PLL enable, and finally releases the external power switch. On a wakeup event it turns the switch back on and waits for the power-good input. It then counts a programmable settle delay, enables the PLL, and waits for PLL lock before it declares the domain ready again.

The settle counter is what keeps the block safe on boards with no power-good source. There, power-good is tied high and only the configured ramp count stands between switch-on and PLL enable. The block can also watch how long lock takes. If lock does not arrive within a fixed number of cycles, it raises a sticky error flag. The wait for lock goes on regardless.

Top module: `wake_sequencer`

## Requirements
- R1: A synchronous active-high reset places the block in the run state (state code 0) with pwr_en=1, pll_en=1, ready=0, busy=0 and lock_err=0.
- R2: In the run state, ready rises on the first clock edge that samples pll_locked high. It then stays high until the block leaves the run state.
- R3: A sleep_req sampled in the run state produces three steps on successive edges. After the first edge ready is low (state 1). After the second, pll_en is low (state 2). After the third, pwr_en is low and the state is sleep (state 3). A sleep_req sampled in any other state is ignored.
- R4: A wake_evt sampled in the sleep state raises pwr_en after that edge, enters the power-wait state (state 4) and keeps pll_en low. A wake_evt sampled in the run state has no effect.
- R5: A wake_evt sampled in state 1 or 2 is held. The sleep state is still reached with pwr_en low for exactly one cycle, and the next edge enters state 4.
- R6: In state 4, pll_en stays low for as long as pwr_good is sampled low.
- R7: Let N be the value of ramp_cfg at the first edge that samples pwr_good high in state 4. pll_en rises exactly N+1 edges after that edge counts as the first. For N>0 the ramp state (code 5) is held in between. N=0 adds no delay.
- R8: If pwr_good is sampled low in the ramp state, the block returns to state 4. The full count is reloaded when pwr_good returns.
- R9: With pwr_good held high throughout, the timing of R7 still applies, counted from the first edge in state 4. The PLL is never enabled sooner.
- R10: In the lock-wait state (code 6), pwr_en and pll_en are high. The edge that samples pll_locked high moves to state 0 with ready high.
- R11: Let L be LOCK_LIMIT. If the first L edges in state 6 all sample pll_locked low, lock_err rises after the L-th edge and stays high until reset. Lock on the L-th edge raises no error.
- R12: busy is high exactly in states 1, 2, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_evt | input | 1 | Wakeup event |
| pwr_good | input | 1 | Switched supply reached its level |
| pll_locked | input | 1 | Core PLL lock indication |
| ramp_cfg | input | RAMP_W | Settle delay in cycles, from a configuration register |
| pwr_en | output | 1 | Enable to the external power switch |
| pll_en | output | 1 | Core PLL enable |
| ready | output | 1 | Domain is operational |
| busy | output | 1 | A power transition is in progress |
| state_o | output | 3 | Current state code |
| lock_err | output | 1 | Sticky lock timeout flag |

## Verification
The power-up path is driven in four ways. Power-good can arrive late, arrive at once, or be tied high. It can also drop mid-ramp. These cases separate a design that gates the PLL on the handshake from one that gates only on the counter, and one that restarts the count from one that resumes it. The ramp count is swept with random values, with zero and one included. This exposes off-by-one errors in when pll_en rises. Wakeups are also sent during the power-down steps and in the run state, which shows whether events are latched or dropped. Lock delays of L-1 and L cycles pin down the exact edge at which the timeout fires.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_DROP_RDY  = 3'd1,
    ST_DROP_PLL  = 3'd2,
    ST_SLEEP     = 3'd3,
    ST_PWR_WAIT  = 3'd4,
    ST_RAMP      = 3'd5,
    ST_LOCK_WAIT = 3'd6
  } wseq_state_e;

  // Supply switch is on everywhere except in the sleep state.
  function automatic logic supply_on(wseq_state_e s);
    return s != ST_SLEEP;
  endfunction

  // PLL runs in run state, first drop step, and while waiting for lock.
  function automatic logic clock_on(wseq_state_e s);
    return (s == ST_RUN) || (s == ST_DROP_RDY) || (s == ST_LOCK_WAIT);
  endfunction

  // Any state between the two resting states counts as a transition.
  function automatic logic in_transit(wseq_state_e s);
    return !((s == ST_RUN) || (s == ST_SLEEP));
  endfunction

  // A wakeup seen during the drop steps is kept for later.
  function automatic logic keeps_wake(wseq_state_e s);
    return (s == ST_DROP_RDY) || (s == ST_DROP_PLL);
  endfunction

endpackage

// File: rtl/wake_ramp_timer.sv
module wake_ramp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  output logic             last,
  output logic             cfg_zero
);

  logic [CNT_W-1:0] cnt_q;

  // Final ramp cycle: one count left.
  function automatic logic at_last(logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (active && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last     = active && at_last(cnt_q);
  assign cfg_zero = (load_val == '0);

  // R7
  ramp_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q != '0));

endmodule

// File: rtl/wake_lock_watch.sv
module wake_lock_watch #(
  parameter bit TIMEOUT_EN = 1'b1,
  parameter int LOCK_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  input  logic locked,
  output logic lock_err
);

  localparam int LW = $clog2(LOCK_LIMIT + 1);

  generate
    if (TIMEOUT_EN) begin : g_watch
      logic [LW-1:0] wait_cnt_q;
      logic          err_q;
      logic          expire;

      assign expire = waiting && !locked && (wait_cnt_q == LW'(LOCK_LIMIT - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          wait_cnt_q <= '0;
          err_q      <= 1'b0;
        end else begin
          if (!waiting) begin
            wait_cnt_q <= '0;
          end else if (!locked && (wait_cnt_q != LW'(LOCK_LIMIT))) begin
            wait_cnt_q <= wait_cnt_q + LW'(1);
          end
          if (expire) begin
            err_q <= 1'b1;
          end
        end
      end

      assign lock_err = err_q;

      // R11
      err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> lock_err);

      // R11
      err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_err) |-> ($past(waiting) && !$past(locked)));
    end else begin : g_nowatch
      logic unused_in;
      assign unused_in = waiting ^ locked ^ clk ^ rst;
      assign lock_err  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sleep_req,
  input  logic        wake_evt,
  input  logic        pwr_good,
  input  logic        pll_locked,
  input  logic        ramp_last,
  input  logic        ramp_zero,
  output wseq_state_e state_q,
  output logic        rdy_q,
  output logic        ramp_load,
  output logic        ramp_active,
  output logic        lock_waiting
);

  wseq_state_e state_d;
  logic        wake_pend_q;
  logic        wake_now;
  logic        go_lock;

  assign wake_now     = wake_evt || wake_pend_q;
  assign ramp_load    = (state_q == ST_PWR_WAIT) && pwr_good && !ramp_zero;
  assign ramp_active  = (state_q == ST_RAMP);
  assign lock_waiting = (state_q == ST_LOCK_WAIT);
  assign go_lock      = ((state_q == ST_PWR_WAIT) && pwr_good && ramp_zero) ||
                        ((state_q == ST_RAMP) && pwr_good && ramp_last);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (sleep_req) state_d = ST_DROP_RDY;
      ST_DROP_RDY:  state_d = ST_DROP_PLL;
      ST_DROP_PLL:  state_d = ST_SLEEP;
      ST_SLEEP:     if (wake_now) state_d = ST_PWR_WAIT;
      ST_PWR_WAIT:  if (go_lock) state_d = ST_LOCK_WAIT;
                    else if (ramp_load) state_d = ST_RAMP;
      ST_RAMP:      if (!pwr_good) state_d = ST_PWR_WAIT;
                    else if (go_lock) state_d = ST_LOCK_WAIT;
      ST_LOCK_WAIT: if (pll_locked) state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      wake_pend_q <= 1'b0;
      rdy_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SLEEP) begin
        wake_pend_q <= 1'b0;
      end else if (keeps_wake(state_q) && wake_evt) begin
        wake_pend_q <= 1'b1;
      end
      if (state_d != ST_RUN) begin
        rdy_q <= 1'b0;
      end else if ((state_q == ST_LOCK_WAIT) || pll_locked) begin
        rdy_q <= 1'b1;
      end
    end
  end

  // R5
  pend_serve_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && wake_pend_q) |=> (state_q == ST_PWR_WAIT));

  // R6
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK_WAIT && $past(state_q) != ST_LOCK_WAIT) |->
      ($past(pwr_good) && ($past(ramp_last) || $past(ramp_zero))));

  // R3
  sleep_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PWR_WAIT && !pwr_good) |=> (state_q == ST_PWR_WAIT));

endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
  import wake_seq_pkg::*;
#(
  parameter int RAMP_W     = 8,
  parameter bit TIMEOUT_EN = 1'b1,
  parameter int LOCK_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              wake_evt,
  input  logic              pwr_good,
  input  logic              pll_locked,
  input  logic [RAMP_W-1:0] ramp_cfg,
  output logic              pwr_en,
  output logic              pll_en,
  output logic              ready,
  output logic              busy,
  output logic [2:0]        state_o,
  output logic              lock_err
);

  wseq_state_e state_q;
  logic        rdy_q;
  logic        ramp_load;
  logic        ramp_active;
  logic        ramp_last;
  logic        ramp_zero;
  logic        lock_waiting;

  wake_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .sleep_req    (sleep_req),
    .wake_evt     (wake_evt),
    .pwr_good     (pwr_good),
    .pll_locked   (pll_locked),
    .ramp_last    (ramp_last),
    .ramp_zero    (ramp_zero),
    .state_q      (state_q),
    .rdy_q        (rdy_q),
    .ramp_load    (ramp_load),
    .ramp_active  (ramp_active),
    .lock_waiting (lock_waiting)
  );

  wake_ramp_timer #(.CNT_W(RAMP_W)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .load     (ramp_load),
    .load_val (ramp_cfg),
    .active   (ramp_active),
    .last     (ramp_last),
    .cfg_zero (ramp_zero)
  );

  wake_lock_watch #(.TIMEOUT_EN(TIMEOUT_EN), .LOCK_LIMIT(LOCK_LIMIT)) u_watch (
    .clk      (clk),
    .rst      (rst),
    .waiting  (lock_waiting),
    .locked   (pll_locked),
    .lock_err (lock_err)
  );

  assign pwr_en  = supply_on(state_q);
  assign pll_en  = clock_on(state_q);
  assign busy    = in_transit(state_q);
  assign ready   = (state_q == ST_RUN) && rdy_q;
  assign state_o = state_q;

  // R3
  drop_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> (!pll_en && !$past(pll_en) && !ready));

  // R2
  ready_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (pll_en && pwr_en && !busy));

  // R9
  pll_after_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> (pwr_en && $past(pwr_en)));

endmodule

// File: tb/wake_sequencer_test.sv
`timescale 1ns/1ps
module wake_sequencer_test;

  localparam int RW  = 6;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst, sleep_req, wake_evt, pwr_good, pll_locked;
  logic [RW-1:0] ramp_cfg;
  logic pwr_en, pll_en, ready, busy, lock_err;
  logic [2:0] state_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_sequencer #(.RAMP_W(RW), .TIMEOUT_EN(1'b1), .LOCK_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .pwr_good(pwr_good), .pll_locked(pll_locked), .ramp_cfg(ramp_cfg),
    .pwr_en(pwr_en), .pll_en(pll_en), .ready(ready), .busy(busy),
    .state_o(state_o), .lock_err(lock_err)
  );

  function automatic int pll_edges(int n);
    return n + 1;
  endfunction

  function automatic int busy_of(int s);
    return (s == 0 || s == 3) ? 0 : 1;
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  // Sleep entry; early=1 injects a wakeup during the drop steps.
  task automatic do_sleep(input bit early, input bit tied);
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R3 ready step1", ready, 0);
    chk("R3 pll step1", pll_en, 1);
    chk("R3 state step1", state_o, 1);
    chk("R12 busy step1", busy, busy_of(1));
    if (early) wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    pll_locked = 1'b0;
    chk("R3 pll step2", pll_en, 0);
    chk("R3 pwr step2", pwr_en, 1);
    tick();
    chk("R3 pwr step3", pwr_en, 0);
    chk("R3 state step3", state_o, 3);
    chk("R12 busy sleep", busy, 0);
    pwr_good = tied;
  endtask

  task automatic wake_up(input int cfg, input int pgd, input bit tied, input bit early);
    ramp_cfg = RW'(cfg);
    if (!early) wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    chk(early ? "R5 latched wake" : "R4 wake pwr", pwr_en, 1);
    chk("R4 wake state", state_o, 4);
    chk("R4 wake pll", pll_en, 0);
    for (int k = 0; k < pgd; k++) begin
      sleep_req = (k == 0);
      tick();
      chk("R6 pll held", pll_en, 0);
      chk("R3 sleep ignored", state_o, 4);
    end
    sleep_req = 1'b0;
    pwr_good = 1'b1;
    for (int i = 1; i <= pll_edges(cfg); i++) begin
      tick();
      chk(tied ? "R9 ramp timing" : "R7 ramp timing", pll_en, (i == pll_edges(cfg)) ? 1 : 0);
    end
    chk("R10 lock state", state_o, 6);
  endtask

  task automatic lock_after(input int m);
    for (int k = 0; k < m; k++) begin
      tick();
      chk("R10 wait lock", ready, 0);
      chk("R12 busy lock", busy, 1);
    end
    pll_locked = 1'b1;
    tick();
    chk("R10 ready", ready, 1);
    chk("R10 run", state_o, 0);
    chk("R12 busy run", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sleep_req = 1'b0; wake_evt = 1'b0; pwr_good = 1'b0;
    pll_locked = 1'b0; ramp_cfg = '0;
    void'($urandom(32'h1F2E3D));
    @(negedge clk);
    do_reset();
    chk("R1 state", state_o, 0);
    chk("R1 pwr", pwr_en, 1);
    chk("R1 pll", pll_en, 1);
    chk("R1 ready", ready, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", lock_err, 0);
    tick();
    chk("R2 no lock", ready, 0);
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    chk("R4 run wake ignored", state_o, 0);
    pll_locked = 1'b1;
    tick();
    chk("R2 ready rise", ready, 1);
    pll_locked = 1'b0;
    tick();
    chk("R2 ready held", ready, 1);

    // Plain cycle with late power-good and nonzero ramp
    do_sleep(1'b0, 1'b0);
    repeat (4) begin
      tick();
      chk("R4 sleep holds", pwr_en, 0);
    end
    wake_up(5, 3, 1'b0, 1'b0);
    lock_after(2);
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    chk("R4 run wake ignored 2", ready, 1);

    // Zero and one ramp counts
    do_sleep(1'b0, 1'b0);
    wake_up(0, 0, 1'b0, 1'b0);
    lock_after(0);
    do_sleep(1'b0, 1'b0);
    wake_up(1, 1, 1'b0, 1'b0);
    lock_after(1);

    // Latched wake, tied power-good
    do_sleep(1'b1, 1'b1);
    wake_up(9, 0, 1'b1, 1'b1);
    lock_after(3);

    // Power-good loss in ramp
    do_sleep(1'b0, 1'b0);
    ramp_cfg = RW'(12);
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    pwr_good = 1'b1;
    tick();
    chk("R7 ramp state", state_o, 5);
    repeat (3) begin
      tick();
      chk("R7 pll off in ramp", pll_en, 0);
    end
    pwr_good = 1'b0;
    tick();
    chk("R8 back to wait", state_o, 4);
    chk("R8 pll off", pll_en, 0);
    pwr_good = 1'b1;
    for (int i = 1; i <= pll_edges(12); i++) begin
      tick();
      chk("R8 full reload", pll_en, (i == pll_edges(12)) ? 1 : 0);
    end
    lock_after(LIM - 1);
    chk("R11 no err at limit", lock_err, 0);

    // Timeout
    do_sleep(1'b0, 1'b0);
    wake_up(2, 0, 1'b0, 1'b0);
    for (int k = 1; k <= LIM; k++) begin
      tick();
      chk("R11 err edge", lock_err, (k == LIM) ? 1 : 0);
    end
    lock_after(0);
    do_sleep(1'b0, 1'b0);
    wake_up(3, 0, 1'b0, 1'b0);
    lock_after(0);
    chk("R11 sticky", lock_err, 1);
    do_reset();
    chk("R1 err cleared", lock_err, 0);
    pll_locked = 1'b1;
    tick();

    // Random cycles
    for (int it = 0; it < 30; it++) begin
      int cfg, pgd, lk, extra;
      bit tied, early;
      cfg   = $urandom_range(0, (1 << RW) - 1);
      tied  = ($urandom_range(0, 3) == 0);
      early = ($urandom_range(0, 3) == 0);
      pgd   = tied ? 0 : $urandom_range(0, 4);
      lk    = $urandom_range(0, LIM - 1);
      extra = $urandom_range(0, 3);
      do_sleep(early, tied);
      if (!early) begin
        for (int k = 0; k < extra; k++) begin
          tick();
          chk("R4 sleep holds rnd", pwr_en, 0);
        end
      end
      wake_up(cfg, pgd, tied, early);
      lock_after(lk);
      chk("R11 no err rnd", lock_err, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule